// File: doc/BRIEF.md
# I2C TPM Register Transaction Sequencer

This block sits between a host that issues register reads and writes and a byte-level I2C master that talks to a TPM-style device. Each host request carries an address, a length of one to four bytes, a direction and write data. The block folds the host address onto the device's 8-bit register index and emits the START, address-byte, index-byte, data-byte and STOP commands. Read data comes back assembled little-endian.

Before it accepts any host request, the block reads the device's 32-bit capability register and takes the per-direction guard delay from it. Until then a default guard delay follows every transaction. The block retries a transaction that the device NACKs, after a fixed error delay. It also checks read data from a few known registers against must-be-zero masks, and reissues the whole read when the check fails. One shared retry budget bounds both kinds of retry. Delays are counted in pulses of a microsecond tick input.

Top module: `i2c_reg_seq`

## Requirements
- R1: The register index is taken from the low 12 bits of the host address; higher bits are ignored. 0x000 maps to index 0x04, 0xFFF to 0x00, 0xF00 to 0x48 and 0xF04 to 0x4C. Any other value uses its low 8 bits.
- R2: A write is one transaction with commands in this order: START; write byte {DEV_ADDR,0}; write the index; write the data bytes least significant first; STOP. The command codes are 0 START, 1 write byte, 2 read byte and 3 STOP.
- R3: A read is two transactions. The first is START, {DEV_ADDR,0}, the index, STOP. The second is START, {DEV_ADDR,1}, then `len` read commands with `cmd_last` high on the final one only, then STOP. `rsp_rdata` holds the bytes little-endian, with unread upper bytes zero.
- R4: After reset the block reads index 0x30 with length 4 before `req_ready` first rises. Until that read completes, DEF_GUARD_US ticks are waited after every transaction.
- R5: Once the capability value is loaded, the guard length is its bits 16:9. The read guard is on if bit 20 or bit 19 is set, and the write guard is on if bit 18 or bit 17 is set. The guard follows each transaction of that direction; the index transaction of a read counts as a write.
- R6: When a written byte is NACKed, the block issues STOP, waits ERR_US ticks and reissues the same transaction from START.
- R7: Read data is checked against must-be-zero masks: 0x48 at index 0x04, 0x23 at 0x18, 0x0FFFF000 at 0x14 and 0x80000000 at 0x30. When a masked bit is set, the block waits for the read guard and then ERR_US ticks, and repeats the whole read.
- R8: The must-be-zero check applies only to lengths 1, 2 and 4 at those four indices. All other reads are returned unchecked.
- R9: NACK retries and check retries share one budget of RETRIES reissues per request. When it is exhausted, `rsp_done` pulses with `rsp_err` high, and the bus has already been released by a STOP.
- R10: Only one request is in flight at a time. `req_ready` is low from acceptance until it rises together with the one-cycle `rsp_done` pulse. Each command is held stable until `cmd_done`.
- R11: While reset is asserted, `req_ready` and `rsp_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One pulse per microsecond |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and accepting |
| req_addr | input | 16 | Host register address |
| req_len | input | 3 | Byte count, 1 to 4 |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_done | output | 1 | Request finished (one cycle) |
| rsp_err | output | 1 | Retries exhausted, valid with rsp_done |
| rsp_rdata | output | 32 | Read data |
| cmd_valid | output | 1 | Command to the byte master |
| cmd_op | output | 2 | 0 START, 1 write, 2 read, 3 STOP |
| cmd_byte | output | 8 | Byte to write |
| cmd_last | output | 1 | Final read byte (master NACKs) |
| cmd_done | input | 1 | Command complete (one cycle) |
| cmd_nack | input | 1 | Written byte was NACKed, valid with cmd_done |
| cmd_rbyte | input | 8 | Read byte, valid with cmd_done |

## Verification
The block registers every decision, so the next command is offered the cycle after `cmd_done`. After the STOP of a transaction, a guard of N ticks delays the next START, or `rsp_done`, by N+2 cycles when the tick is held high. An error wait that follows a read guard adds ERR_US+1 more cycles. The bench drives and samples on falling edges, logs each command with the cycle it was accepted and the cycle it completed, and checks these gaps in windows of plus or minus one cycle around the expected value. Result data, command order, bytes and START counts are read from the log after `rsp_done`, so none of them depends on the exact cycle.

// File: rtl/i2c_reg_seq.sv
module i2c_reg_seq #(
  parameter logic [6:0] DEV_ADDR     = 7'h2E,
  parameter int         RETRIES      = 3,
  parameter int         DEF_GUARD_US = 250,
  parameter int         ERR_US       = 250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_addr,
  input  logic [2:0]  req_len,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        rsp_done,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        cmd_valid,
  output logic [1:0]  cmd_op,
  output logic [7:0]  cmd_byte,
  output logic        cmd_last,
  input  logic        cmd_done,
  input  logic        cmd_nack,
  input  logic [7:0]  cmd_rbyte
);
  localparam int MAX1 = (DEF_GUARD_US > ERR_US) ? DEF_GUARD_US : ERR_US;
  localparam int MAXV = (MAX1 > 255) ? MAX1 : 255;
  localparam int CW   = $clog2(MAXV + 1);
  localparam int TW   = (RETRIES < 1) ? 1 : $clog2(RETRIES + 1);
  localparam logic [1:0] OP_START = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [3:0] {S_IDLE, S_START, S_ADDR, S_IDX, S_WDAT, S_RDAT, S_STOP, S_GUARD, S_ERRW} st_t;

  st_t st;
  logic [7:0]    idx;
  logic [2:0]    len;
  logic          wr, rdph, nacked, boot, g_rd, g_wr;
  logic [31:0]   wdata, rdata;
  logic [1:0]    bcnt;
  logic [TW-1:0] tries;
  logic [CW-1:0] cnt, g_len;
  logic          done_q, err_q;

  function automatic logic [7:0] map_idx(input logic [11:0] a);
    case (a)
      12'h000: return 8'h04;
      12'hFFF: return 8'h00;
      12'hF00: return 8'h48;
      12'hF04: return 8'h4C;
      default: return a[7:0];
    endcase
  endfunction

  function automatic logic [31:0] zmask(input logic [7:0] i);
    case (i)
      8'h04:   return 32'h0000_0048;
      8'h18:   return 32'h0000_0023;
      8'h14:   return 32'h0FFF_F000;
      8'h30:   return 32'h8000_0000;
      default: return 32'h0;
    endcase
  endfunction

  logic       unused_hi;
  logic [2:0] len_c;
  logic       last_b, chk_bad, g_end, at_limit, fin_ok, fin_err;

  assign unused_hi = ^req_addr[15:12];
  assign len_c     = (req_len == 3'd0) ? 3'd1 : (req_len > 3'd4) ? 3'd4 : req_len;
  assign last_b    = ({1'b0, bcnt} == len - 3'd1);
  assign chk_bad   = (len == 3'd1 || len == 3'd2 || len == 3'd4) && |(rdata & zmask(idx));
  assign g_end     = (st == S_GUARD) && (cnt == '0);
  assign at_limit  = (tries == TW'(RETRIES));
  assign fin_ok    = g_end && (wr || (rdph && !chk_bad));
  assign fin_err   = at_limit && (((st == S_STOP) && cmd_done && nacked) || (g_end && rdph && chk_bad));

  assign req_ready = (st == S_IDLE);
  assign cmd_valid = st inside {S_START, S_ADDR, S_IDX, S_WDAT, S_RDAT, S_STOP};
  assign cmd_last  = (st == S_RDAT) && last_b;
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata;

  always_comb begin
    case (st)
      S_ADDR, S_IDX, S_WDAT: cmd_op = OP_WR;
      S_RDAT:                cmd_op = OP_RD;
      S_STOP:                cmd_op = OP_STOP;
      default:               cmd_op = OP_START;
    endcase
    case (st)
      S_ADDR:  cmd_byte = {DEV_ADDR, rdph};
      S_IDX:   cmd_byte = idx;
      S_WDAT:  cmd_byte = wdata[{bcnt, 3'b000} +: 8];
      default: cmd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_START; boot <= 1'b1; idx <= 8'h30; len <= 3'd4; wr <= 1'b0;
      wdata <= '0; rdata <= '0; bcnt <= '0; rdph <= 1'b0; nacked <= 1'b0;
      tries <= '0; cnt <= '0; g_rd <= 1'b1; g_wr <= 1'b1; g_len <= CW'(DEF_GUARD_US);
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          idx <= map_idx(req_addr[11:0]); len <= len_c; wr <= req_write;
          wdata <= req_wdata; rdph <= 1'b0; tries <= '0; st <= S_START;
        end
        S_START: if (cmd_done) begin nacked <= 1'b0; bcnt <= '0; st <= S_ADDR; end
        S_ADDR: if (cmd_done) begin
          if (cmd_nack) begin nacked <= 1'b1; st <= S_STOP; end
          else if (rdph) begin rdata <= '0; st <= S_RDAT; end
          else st <= S_IDX;
        end
        S_IDX: if (cmd_done) begin
          if (cmd_nack) begin nacked <= 1'b1; st <= S_STOP; end
          else st <= wr ? S_WDAT : S_STOP;
        end
        S_WDAT: if (cmd_done) begin
          if (cmd_nack) begin nacked <= 1'b1; st <= S_STOP; end
          else if (last_b) st <= S_STOP;
          else bcnt <= bcnt + 2'd1;
        end
        S_RDAT: if (cmd_done) begin
          rdata[{bcnt, 3'b000} +: 8] <= cmd_rbyte;
          if (last_b) st <= S_STOP;
          else bcnt <= bcnt + 2'd1;
        end
        S_STOP: if (cmd_done) begin
          if (nacked) begin
            tries <= tries + TW'(1); cnt <= CW'(ERR_US); st <= S_ERRW;
          end else begin
            cnt <= (rdph ? g_rd : g_wr) ? g_len : '0; st <= S_GUARD;
          end
        end
        S_GUARD:
          if (cnt != '0) begin
            if (us_tick) cnt <= cnt - CW'(1);
          end else if (!rdph) begin
            rdph <= 1'b1; st <= S_START;
          end else if (chk_bad) begin
            tries <= tries + TW'(1); cnt <= CW'(ERR_US); rdph <= 1'b0; st <= S_ERRW;
          end
        S_ERRW:
          if (cnt != '0) begin
            if (us_tick) cnt <= cnt - CW'(1);
          end else st <= S_START;
        default: st <= S_IDLE;
      endcase
      if (fin_ok || fin_err) begin
        st   <= S_IDLE;
        boot <= 1'b0;
        if (boot) begin
          if (fin_ok) begin
            g_len <= CW'(rdata[16:9]);
            g_rd  <= rdata[20] | rdata[19];
            g_wr  <= rdata[18] | rdata[17];
          end
        end else begin
          done_q <= 1'b1;
          err_q  <= fin_err;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_reg_seq_chk.sv
module i2c_reg_seq_chk #(
  parameter int RETRIES = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_done,
  input logic       rsp_err,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_byte,
  input logic       cmd_done
);
  logic [7:0] n_start;

  always_ff @(posedge clk) begin
    if (!rst_n) n_start <= '0;
    else if (req_valid && req_ready) n_start <= '0;
    else if (cmd_valid && cmd_done && cmd_op == 2'd0 && n_start != 8'hFF) n_start <= n_start + 8'd1;
  end

  p_idle_no_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  p_cmd_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);

  p_start_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    n_start <= 8'(2 * (RETRIES + 1)));
endmodule

bind i2c_reg_seq i2c_reg_seq_chk #(.RETRIES(RETRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .rsp_err(rsp_err), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_done(cmd_done)
);

// File: tb/i2c_reg_seq_tb.sv
module i2c_reg_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEFG = 20;
  localparam int ERRW = 12;
  localparam int NG   = 5;
  localparam int RET  = 3;
  localparam logic [31:0] CAP = 32'h0010_0A00;
  localparam int WD = 100000;

  logic clk = 0, rst_n = 0, us_tick = 1;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [2:0] req_len = 1;
  logic [31:0] req_wdata = 0;
  logic cmd_done = 0, cmd_nack = 0;
  logic [7:0] cmd_rbyte = 0;
  logic req_ready, rsp_done, rsp_err, cmd_valid, cmd_last;
  logic [31:0] rsp_rdata;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;

  i2c_reg_seq #(.DEV_ADDR(7'h2E), .RETRIES(RET), .DEF_GUARD_US(DEFG), .ERR_US(ERRW)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_last(cmd_last), .cmd_done(cmd_done),
    .cmd_nack(cmd_nack), .cmd_rbyte(cmd_rbyte));

  // addr16 | len4 | wr4 | wdata32 | device data32 | index8 | expected rdata32
  localparam logic [127:0] VEC [8] = '{
    {16'h0FFF, 4'd1, 4'd1, 32'h0000_00A5, 32'h0,          8'h00, 32'h0},
    {16'h0F00, 4'd4, 4'd0, 32'h0,          32'h001B_15D1, 8'h48, 32'h001B_15D1},
    {16'h3F04, 4'd1, 4'd0, 32'h0,          32'h1234_56AB, 8'h4C, 32'h0000_00AB},
    {16'h1000, 4'd1, 4'd0, 32'h0,          32'h0000_00A1, 8'h04, 32'h0000_00A1},
    {16'h0024, 4'd4, 4'd1, 32'hDEAD_BEEF, 32'h0,          8'h24, 32'h0},
    {16'h0018, 4'd2, 4'd0, 32'h0,          32'h0000_0890, 8'h18, 32'h0000_0890},
    {16'h0014, 4'd3, 4'd0, 32'h0,          32'h00FF_F000, 8'h14, 32'h00FF_F000},
    {16'h0F80, 4'd2, 4'd1, 32'h0000_1234, 32'h0,          8'h80, 32'h0}
  };

  int total = 0, bad = 0, cyc = 0;
  int lg_n = 0;
  logic [1:0] lg_op [128];
  logic [7:0] lg_byte [128];
  logic       lg_last [128];
  int         lg_ta [128];
  int         lg_td [128];
  int nack_left = 0, bad_left = 0;
  logic [31:0] bad_val = 0, slv_data = 0, cur_rd = 0;
  logic busy = 0, after_start = 0, p_addr = 0;
  logic [1:0] p_op = 0;
  logic [7:0] p_byte = 0;
  int lat = 0, rp = 0, cur_i = 0;
  logic r_err;
  logic [31:0] r_data;
  int t_rsp;

  initial forever #(CLK_PERIOD / 2) clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin busy = 0; cmd_done = 0; cmd_nack = 0; after_start = 0; end
      else if (cmd_done) begin cmd_done = 0; cmd_nack = 0; end
      else if (busy) begin
        lat--;
        if (lat == 0) begin
          busy = 0; cmd_done = 1; lg_td[cur_i] = cyc;
          if (p_op == 2'd1 && p_addr) begin
            if (nack_left > 0) begin cmd_nack = 1; nack_left--; end
            else if (p_byte[0]) begin
              rp = 0;
              if (bad_left > 0) begin cur_rd = bad_val; bad_left--; end
              else cur_rd = slv_data;
            end
          end else if (p_op == 2'd2) begin
            cmd_rbyte = cur_rd[rp*8 +: 8];
            if (rp < 3) rp++;
          end
        end
      end else if (cmd_valid) begin
        busy = 1; lat = 2; p_op = cmd_op; p_byte = cmd_byte;
        p_addr = (cmd_op == 2'd1) && after_start;
        after_start = (cmd_op == 2'd0);
        cur_i = (lg_n < 128) ? lg_n : 127;
        lg_op[cur_i] = cmd_op; lg_byte[cur_i] = cmd_byte; lg_last[cur_i] = cmd_last;
        lg_ta[cur_i] = cyc; lg_td[cur_i] = 0;
        if (lg_n < 128) lg_n++;
      end
    end
  end

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic ckr(input string tag, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin bad++; $display("FAIL %s act=%0d exp=%0d..%0d", tag, act, lo, hi); end
  endtask

  function automatic int cnt_op(input logic [1:0] op);
    int n = 0;
    for (int i = 0; i < lg_n; i++) if (lg_op[i] == op) n++;
    return n;
  endfunction

  function automatic int nth(input logic [1:0] op, input int k);
    int n = 0;
    for (int i = 0; i < lg_n; i++)
      if (lg_op[i] == op) begin if (n == k) return i; n++; end
    return 0;
  endfunction

  task automatic do_req(input logic [15:0] a, input logic [2:0] l, input logic w, input logic [31:0] d);
    while (!req_ready) @(negedge clk);
    lg_n = 0;
    req_addr = a; req_len = l; req_write = w; req_wdata = d; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    ck("R10 ready low while busy", {31'd0, req_ready}, 32'd0);
    while (!rsp_done) @(negedge clk);
    t_rsp = cyc; r_err = rsp_err; r_data = rsp_rdata;
    ck("R10 ready with done", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    slv_data = CAP;
    repeat (4) @(negedge clk);
    ck("R11 ready in reset", {31'd0, req_ready}, 32'd0);
    ck("R11 done in reset", {31'd0, rsp_done}, 32'd0);
    lg_n = 0;
    rst_n = 1;
    while (!req_ready) @(negedge clk);
    ck("R4 startup index", {24'd0, lg_byte[2]}, 32'h30);
    ck("R4 startup reads", cnt_op(2'd2), 32'd4);
    ckr("R4 default guard", lg_ta[nth(2'd0, 1)] - lg_td[nth(2'd3, 0)], DEFG + 1, DEFG + 3);

    for (int i = 0; i < 8; i++) begin
      logic [127:0] v;
      v = VEC[i];
      slv_data = v[71:40];
      do_req(v[127:112], v[110:108], v[104], v[103:72]);
      ck("R1 index byte", {24'd0, lg_byte[2]}, {24'd0, v[39:32]});
      ck("R2 R3 address byte", {24'd0, lg_byte[1]}, 32'h5C);
      ck("R9 no error", {31'd0, r_err}, 32'd0);
      if (v[104]) begin
        ck("R2 one transaction", cnt_op(2'd0), 32'd1);
        for (int b = 0; b < int'(v[111:108]); b++)
          ck("R2 data byte", {24'd0, lg_byte[3+b]}, {24'd0, v[72+8*b +: 8]});
        ck("R2 stop last", {30'd0, lg_op[lg_n-1]}, 32'd3);
        ckr("R5 write guard off", t_rsp - lg_td[nth(2'd3, 0)], 1, 3);
      end else begin
        ck("R3 two transactions", cnt_op(2'd0), 32'd2);
        ck("R3 read address byte", {24'd0, lg_byte[5]}, 32'h5D);
        ck("R3 rdata", r_data, v[31:0]);
        ck("R3 last flag", {31'd0, lg_last[nth(2'd2, int'(v[111:108]) - 1)]}, 32'd1);
        ckr("R5 index txn write guard off", lg_ta[nth(2'd0, 1)] - lg_td[nth(2'd3, 0)], 1, 3);
        ckr("R5 read guard", t_rsp - lg_td[nth(2'd3, 1)], NG + 1, NG + 3);
      end
    end

    nack_left = 2;
    do_req(16'h0024, 3'd1, 1'b1, 32'h5A);
    ck("R6 nack reissue", cnt_op(2'd0), 32'd3);
    ck("R6 no error", {31'd0, r_err}, 32'd0);
    ck("R6 data after retry", {24'd0, lg_byte[lg_n-2]}, 32'h5A);
    ckr("R6 error wait", lg_ta[nth(2'd0, 1)] - lg_td[nth(2'd3, 0)], ERRW + 1, ERRW + 3);

    slv_data = 32'h80; bad_left = 1; bad_val = 32'h01;
    do_req(16'h0018, 3'd1, 1'b0, 32'h0);
    ck("R7 status reread", cnt_op(2'd0), 32'd4);
    ck("R7 status data", r_data, 32'h80);
    ckr("R7 guard then error wait", lg_ta[nth(2'd0, 2)] - lg_td[nth(2'd3, 1)], NG + ERRW + 2, NG + ERRW + 4);

    slv_data = 32'h21; bad_left = 1; bad_val = 32'h40;
    do_req(16'h0000, 3'd1, 1'b0, 32'h0);
    ck("R7 access reread", cnt_op(2'd0), 32'd4);
    ck("R7 access data", r_data, 32'h21);

    slv_data = 32'h0000_0123; bad_left = 1; bad_val = 32'h0000_1000;
    do_req(16'h0014, 3'd4, 1'b0, 32'h0);
    ck("R7 intf caps reread", cnt_op(2'd0), 32'd4);

    slv_data = CAP; bad_left = 1; bad_val = 32'h8000_0000;
    do_req(16'h0030, 3'd4, 1'b0, 32'h0);
    ck("R7 cap reread", cnt_op(2'd0), 32'd4);
    ck("R7 cap data", r_data, CAP);

    slv_data = 32'h11; bad_left = 1; bad_val = 32'hFF;
    do_req(16'h0024, 3'd1, 1'b0, 32'h0);
    ck("R8 unchecked index", cnt_op(2'd0), 32'd2);
    ck("R8 unchecked data", r_data, 32'hFF);
    bad_left = 0;

    nack_left = 10;
    do_req(16'h0024, 3'd1, 1'b1, 32'h77);
    ck("R9 nack exhausted starts", cnt_op(2'd0), RET + 1);
    ck("R9 nack exhausted err", {31'd0, r_err}, 32'd1);
    ck("R9 bus released", {30'd0, lg_op[lg_n-1]}, 32'd3);
    nack_left = 0;

    slv_data = 32'h0; bad_left = 10; bad_val = 32'h02;
    do_req(16'h0018, 3'd1, 1'b0, 32'h0);
    ck("R9 check exhausted starts", cnt_op(2'd0), 2 * (RET + 1));
    ck("R9 check exhausted err", {31'd0, r_err}, 32'd1);
    bad_left = 0;

    slv_data = 32'h0000_0890;
    do_req(16'h0018, 3'd2, 1'b0, 32'h0);
    ck("R9 recovers after error", r_data, 32'h0000_0890);
    ck("R9 recovers no err", {31'd0, r_err}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule